// File: doc/BRIEF.md
# Dual Programmable Tone Frequency Generator

This block produces two square-wave tones whose pitches are set independently by two 8-bit frequency codes. A shared two-bit range field scales both generators at once, giving a half-resolution, standard or double-resolution step, and the codes themselves are left unchanged. Each generator is a 17-bit phase accumulator. It advances only on cycles where the tick enable input is high. The tick is meant to arrive at 512 kHz, so one code step is exactly 7.8125 Hz in the standard range.

The most significant phase bit of each accumulator drives that generator's tone output, which is a 50% duty square wave. The upper seven phase bits of generator 1 are brought out as a cycle-position index, so that a pulse-width stage downstream can compare against it. A synchronous reset and a power-on-reset command both clear the codes, the range and the phases.

Top module: `dual_tone_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the edge clears both codes, the range and both phases, so `tone1`, `tone2` and `pos1` read 0 after it.
- R2: With range 2'b00 (standard), each clock edge with `tick` high adds code*2 to that generator's 17-bit phase, modulo 2^17. At a 512 kHz tick this gives code*7.8125 Hz, and each tone output is its phase bit 16.
- R3: With range 2'b10 (bit 1 = double), each tick adds code*4 to the phase, a 15.625 Hz step.
- R4: With range 2'b01 (bit 0 = half), each tick adds code*1 to the phase, a 3.90625 Hz step.
- R5: Range 2'b11 behaves exactly like the standard range.
- R6: `wr_f1` loads `f1_code` and `wr_f2` loads `f2_code`, each on its own. The stored range, loaded by `wr_rng` from `rng_sel`, scales both generators together.
- R7: A clock edge with `por_clr` high clears both codes, the range (back to standard) and both phases, whatever writes are requested in that cycle.
- R8: A stored code of zero holds that generator's phase at 0, so its tone stays low.
- R9: On edges with `tick` low, the phases keep their values.
- R10: `pos1` equals bits 16 to 10 of generator 1's phase, an index from 0 to 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| por_clr | input | 1 | Power-on-reset command, clears all settings and phases |
| tick | input | 1 | Phase advance enable (512 kHz rate) |
| wr_f1 | input | 1 | Write strobe for the generator 1 code |
| f1_code | input | 8 | Generator 1 frequency code |
| wr_f2 | input | 1 | Write strobe for the generator 2 code |
| f2_code | input | 8 | Generator 2 frequency code |
| wr_rng | input | 1 | Write strobe for the range field |
| rng_sel | input | 2 | Range: bit 1 double, bit 0 half, 11 = standard |
| tone1 | output | 1 | Generator 1 square wave |
| tone2 | output | 1 | Generator 2 square wave |
| pos1 | output | 7 | Generator 1 cycle-position index |

## Verification
The bench compares the phase seen through `pos1` and both tone outputs against an arithmetic model after runs long enough to wrap the 17-bit accumulator. A wrong width or a lost carry would therefore show up as a wrong index. Each range code is paired with different codes on the two generators. A design that swapped the half and double shifts, treated 2'b11 as a fourth scale, or let one generator's write reach the other would produce a mismatched phase. Directed cases cover a zero code, which must keep its tone low, and idle ticks, which must leave the phase frozen. They also cover a power-on-reset command followed by a code-only write, so a range that survives the clear is caught by the wrong step size.

// File: rtl/tone_pkg.sv
package tone_pkg;
   // Range field encoding: bit 1 selects double step, bit 0 selects half step
   typedef enum logic [1:0] {
      RNG_STD  = 2'b00,
      RNG_HALF = 2'b01,
      RNG_DBL  = 2'b10,
      RNG_BOTH = 2'b11
   } rng_e;

   // Left shift applied to the code to form the phase increment
   function automatic logic [1:0] rng_shift(rng_e r);
      case (r)
         RNG_HALF: return 2'd0;
         RNG_DBL:  return 2'd2;
         default:  return 2'd1;   // standard and the both-set case
      endcase
   endfunction
endpackage

// File: rtl/tone_cfg_regs.sv
module tone_cfg_regs #(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_clr,
   input  logic              wr_f1,
   input  logic [CODE_W-1:0] f1_code,
   input  logic              wr_f2,
   input  logic [CODE_W-1:0] f2_code,
   input  logic              wr_rng,
   input  logic [1:0]        rng_sel,
   output logic [CODE_W-1:0] code1,
   output logic [CODE_W-1:0] code2,
   output tone_pkg::rng_e    rng
);
   always_ff @(posedge clk) begin
      if (!rst_n || por_clr) begin
         code1 <= '0;
         code2 <= '0;
         rng   <= tone_pkg::RNG_STD;
      end else begin
         if (wr_f1)  code1 <= f1_code;
         if (wr_f2)  code2 <= f2_code;
         if (wr_rng) rng   <= tone_pkg::rng_e'(rng_sel);
      end
   end
endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
   parameter int CODE_W = 8,
   parameter int ACC_W  = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   input  logic [1:0]        shift,
   output logic [ACC_W-1:0]  phase
);
   localparam int INC_W = CODE_W + 2;

   logic [INC_W-1:0] inc;
   logic             idle;

   always_comb begin
      inc  = INC_W'(code) << shift;
      idle = (code == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr || idle)
         phase <= '0;
      else if (tick)
         phase <= phase + ACC_W'(inc);
   end
endmodule

// File: rtl/dual_tone_gen.sv
module dual_tone_gen #(
   parameter int CODE_W = 8,
   parameter int ACC_W  = 17,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_clr,
   input  logic              tick,
   input  logic              wr_f1,
   input  logic [CODE_W-1:0] f1_code,
   input  logic              wr_f2,
   input  logic [CODE_W-1:0] f2_code,
   input  logic              wr_rng,
   input  logic [1:0]        rng_sel,
   output logic              tone1,
   output logic              tone2,
   output logic [IDX_W-1:0]  pos1
);
   localparam int NGEN  = 2;
   localparam int INC_W = CODE_W + 2;

   if (ACC_W < INC_W + 1) begin : g_bad_acc
      $error("ACC_W too narrow for the largest increment");
   end
   if (IDX_W > ACC_W || IDX_W < 1) begin : g_bad_idx
      $error("IDX_W must lie between 1 and ACC_W");
   end

   logic [CODE_W-1:0] code1, code2;
   tone_pkg::rng_e    rng;
   logic [1:0]        shift;
   logic [CODE_W-1:0] codes  [NGEN];
   logic [ACC_W-1:0]  phases [NGEN];

   tone_cfg_regs #(.CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .por_clr(por_clr),
      .wr_f1(wr_f1), .f1_code(f1_code),
      .wr_f2(wr_f2), .f2_code(f2_code),
      .wr_rng(wr_rng), .rng_sel(rng_sel),
      .code1(code1), .code2(code2), .rng(rng)
   );

   always_comb begin
      shift    = tone_pkg::rng_shift(rng);
      codes[0] = code1;
      codes[1] = code2;
   end

   for (genvar g = 0; g < NGEN; g++) begin : g_gen
      tone_phase #(.CODE_W(CODE_W), .ACC_W(ACC_W)) u_ph (
         .clk(clk), .rst_n(rst_n), .clr(por_clr), .tick(tick),
         .code(codes[g]), .shift(shift), .phase(phases[g])
      );
   end

   assign tone1 = phases[0][ACC_W-1];
   assign tone2 = phases[1][ACC_W-1];
   assign pos1  = phases[0][ACC_W-1 -: IDX_W];
endmodule

// File: rtl/tone_gen_chk.sv
module tone_gen_chk #(
   parameter int CODE_W = 8,
   parameter int IDX_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              por_clr,
   input logic              tick,
   input logic              wr_f1,
   input logic [CODE_W-1:0] f1_code,
   input logic              wr_f2,
   input logic              tone1,
   input logic              tone2,
   input logic [IDX_W-1:0]  pos1
);
   // R1
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> (pos1 == '0 && !tone1 && !tone2));

   // R7
   por_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      por_clr |=> (pos1 == '0 && !tone1 && !tone2));

   // R8
   zero_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_f1 && f1_code == '0) |=> ##1 (pos1 == '0 && !tone1));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !por_clr && !wr_f1 && !wr_f2 && !$past(wr_f1) && !$past(wr_f2))
      |=> ($stable(pos1) && $stable(tone1) && $stable(tone2)));
endmodule

bind dual_tone_gen tone_gen_chk #(.CODE_W(CODE_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .por_clr(por_clr), .tick(tick),
   .wr_f1(wr_f1), .f1_code(f1_code), .wr_f2(wr_f2),
   .tone1(tone1), .tone2(tone2), .pos1(pos1)
);

// File: tb/sim_dual_tone_gen.sv
`timescale 1ns/1ps
module sim_dual_tone_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_clr = 1'b0;
   logic       tick = 1'b0;
   logic       wr_f1 = 1'b0, wr_f2 = 1'b0, wr_rng = 1'b0;
   logic [7:0] f1_code = '0, f2_code = '0;
   logic [1:0] rng_sel = '0;
   logic       tone1, tone2;
   logic [6:0] pos1;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dual_tone_gen u0 (
      .clk(clk), .rst_n(rst_n), .por_clr(por_clr), .tick(tick),
      .wr_f1(wr_f1), .f1_code(f1_code), .wr_f2(wr_f2), .f2_code(f2_code),
      .wr_rng(wr_rng), .rng_sel(rng_sel),
      .tone1(tone1), .tone2(tone2), .pos1(pos1)
   );

   // {code1, code2, range, tick count}
   localparam logic [33:0] VEC [8] = '{
      {8'd100, 8'd37,  2'd0, 16'd50},
      {8'd255, 8'd1,   2'd2, 16'd200},
      {8'd255, 8'd200, 2'd1, 16'd300},
      {8'd64,  8'd128, 2'd3, 16'd100},
      {8'd0,   8'd90,  2'd0, 16'd40},
      {8'd17,  8'd0,   2'd2, 16'd1000},
      {8'd1,   8'd255, 2'd1, 16'd5},
      {8'd128, 8'd128, 2'd0, 16'd256}
   };

   // Phase model from the requirements: multiplier 1 half, 4 double, else 2
   function automatic int model_phase(int code, int rng, int n);
      int m;
      m = (rng == 1) ? 1 : (rng == 2) ? 4 : 2;
      return (n * code * m) % 131072;
   endfunction

   function automatic string rng_req(int rng);
      case (rng)
         0: return "R2";
         1: return "R4";
         2: return "R3";
         default: return "R5";
      endcase
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_ticks(int n);
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic por_pulse();
      por_clr = 1'b1;
      @(negedge clk);
      por_clr = 1'b0;
   endtask

   initial begin
      #5_000_000;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int p1, p2, c1, c2, rg, n;
      // R1: reset state
      repeat (2) @(negedge clk);
      chk("R1 tone1", tone1, 0);
      chk("R1 tone2", tone2, 0);
      chk("R1 pos1", pos1, 0);
      rst_n = 1'b1;
      @(negedge clk);

      foreach (VEC[i]) begin
         c1 = VEC[i][33:26];
         c2 = VEC[i][25:18];
         rg = VEC[i][17:16];
         n  = VEC[i][15:0];
         por_pulse();
         wr_f1 = 1'b1; f1_code = 8'(c1);
         wr_f2 = 1'b1; f2_code = 8'(c2);
         wr_rng = 1'b1; rng_sel = 2'(rg);
         @(negedge clk);
         wr_f1 = 1'b0; wr_f2 = 1'b0; wr_rng = 1'b0;
         run_ticks(n);
         p1 = model_phase(c1, rg, n);
         p2 = model_phase(c2, rg, n);
         // R10 index, R6 independent codes, R8 when a code is zero
         chk({rng_req(rg), " R10 pos1"}, pos1, p1 >> 10);
         chk({rng_req(rg), " R8 tone1"}, tone1, p1 >> 16);
         chk({rng_req(rg), " R6 tone2"}, tone2, p2 >> 16);
      end

      // R9: idle cycles hold the phase
      p1 = pos1;
      repeat (6) @(negedge clk);
      chk("R9 pos1 idle", pos1, p1);
      chk("R9 tone1 idle", tone1, 1);

      // R7: clear, then code-only write runs at the standard step
      por_pulse();
      chk("R7 pos1", pos1, 0);
      chk("R7 tone1", tone1, 0);
      chk("R7 tone2", tone2, 0);
      run_ticks(20);
      chk("R7 cleared code stays idle", pos1, 0);
      wr_rng = 1'b1; rng_sel = 2'd2;
      @(negedge clk);
      wr_rng = 1'b0;
      por_pulse();
      wr_f1 = 1'b1; f1_code = 8'd10;
      @(negedge clk);
      wr_f1 = 1'b0;
      run_ticks(1000);
      chk("R7 range back to standard", pos1, model_phase(10, 0, 1000) >> 10);

      // R7: clear wins over a write in the same cycle
      por_clr = 1'b1; wr_f1 = 1'b1; f1_code = 8'd200;
      @(negedge clk);
      por_clr = 1'b0; wr_f1 = 1'b0;
      run_ticks(50);
      chk("R7 write during clear ignored", pos1, 0);

      // R6: writing only code 2 leaves generator 1 untouched
      wr_f1 = 1'b1; f1_code = 8'd40;
      @(negedge clk);
      wr_f1 = 1'b0;
      run_ticks(100);
      wr_f2 = 1'b1; f2_code = 8'd3;
      @(negedge clk);
      wr_f2 = 1'b0;
      run_ticks(100);
      chk("R6 gen1 unaffected by gen2 write", pos1, model_phase(40, 0, 200) >> 10);

      // R1: reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 mid-run pos1", pos1, 0);
      run_ticks(30);
      chk("R1 code cleared", pos1, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule